// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Three-Sample Voting

This block receives asynchronous serial frames on a single line that has already been synchronised to the system clock. A programmable divider produces a sample tick. Each bit lasts 16 ticks, or 8 ticks when double speed is selected. Three samples around the centre of each bit are combined by majority vote. A start bit that votes high is treated as a glitch, and the block goes back to waiting for a falling edge.

The frame has 5 to 9 data bits, sent LSB first. An optional even or odd parity bit follows, then the stop bit. Only the first stop bit is examined, so one and two stop bits are both received correctly. Each completed frame is written, together with its own frame-error and parity-error bits, into a status FIFO. The oldest entry is presented on the outputs until a read strobe removes it.

An address-filter mode discards every frame whose last data bit is zero. Clearing the receive enable abandons any frame in progress at once.

Top module: `uart_rx_maj`

## Requirements
- R1: A sample tick occurs once every `baud_div`+1 clock cycles.
- R2: A bit lasts 16 ticks when `dbl_speed` is 0 and 8 ticks when it is 1. The three votes are taken at ticks 7, 8 and 9 of the bit in normal mode, and at ticks 3, 4 and 5 in double-speed mode.
- R3: The receiver waits in a hunt state for a low sample. If the start bit then votes high, the frame is dropped and hunting resumes. A later valid frame is still received.
- R4: `len_code` 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits; codes 5 to 7 also select 9. Data arrives LSB first. `rx_data` carries bits 7..0 and `rx_bit8` carries bit 8. Data bits above the selected length read as zero.
- R5: `par_mode` 2'b00 and 2'b01 select no parity, 2'b10 selects even parity and 2'b11 selects odd parity. A parity bit that does not match the selected mode sets `err_parity` for that entry.
- R6: Only the first stop bit is checked. If it votes low, `err_frame` is set for that entry, and the frame is still stored.
- R7: The FIFO holds two entries. `rx_valid` is high while the FIFO is not empty. `rd_strobe` removes the head entry. The error flags shown on the outputs always belong to the head entry.
- R8: A frame that completes while both entries are full, with no read in the same cycle, is lost. The newest stored entry then carries `err_overrun`=1. An entry written normally carries `err_overrun`=0.
- R9: While `rx_en` is 0, no frame is received and any partial frame is discarded. Entries already in the FIFO are kept.
- R10: While `addr_filter` is 1, a frame whose last data bit is 0 is not stored, and a frame whose last data bit is 1 is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, already synchronised |
| rx_en | input | 1 | Receive enable |
| baud_div | input | 12 | Tick divisor; tick period is baud_div+1 clocks |
| dbl_speed | input | 1 | Selects 8 ticks per bit instead of 16 |
| len_code | input | 3 | Data length code |
| par_mode | input | 2 | Parity selection |
| addr_filter | input | 1 | Drop frames whose last data bit is 0 |
| rd_strobe | input | 1 | Remove the head entry |
| rx_valid | output | 1 | FIFO holds at least one entry |
| rx_data | output | 8 | Head entry, data bits 7..0 |
| rx_bit8 | output | 1 | Head entry, data bit 8 |
| err_frame | output | 1 | Head entry, stop bit was low |
| err_parity | output | 1 | Head entry, parity mismatch |
| err_overrun | output | 1 | Head entry, a later frame was lost |

## Verification
The assertions assume that `baud_div`, `dbl_speed`, `len_code` and `par_mode` do not change while a frame is being received. The stimulus changes these inputs only while the line is idle, between frames. The tick-spacing property also assumes that the divisor is held constant. The bench sets the divisor once before each group of frames and never changes it while ticks are counting through a frame. Every frame the bench sends lasts a whole number of bit periods computed from the same divisor, so each of the three votes falls well inside its bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int RX_MAX_BITS = 9;
   localparam int RX_IDX_W    = $clog2(RX_MAX_BITS);

   typedef enum logic [2:0] {ST_HUNT, ST_START, ST_DATA, ST_PARITY, ST_STOP} rx_state_e;

   typedef struct packed {
      logic [RX_MAX_BITS-1:0] data;
      logic                   fe;
      logic                   pe;
   } rx_entry_t;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   // index of the last data bit for a length code
   function automatic logic [RX_IDX_W-1:0] last_bit_idx(input logic [2:0] code);
      return (code >= 3'd4) ? RX_IDX_W'(RX_MAX_BITS-1) : RX_IDX_W'(code) + RX_IDX_W'(4);
   endfunction
endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   if (DIV_W < 1) begin : g_bad_width
      $error("uart_rx_tick: DIV_W must be positive");
   end

   logic [DIV_W-1:0] cnt_q;

   assign tick = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= div;
      else           cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int PH_W = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      rxd,
   input  logic      rx_en,
   input  logic      dbl,
   input  logic [2:0] len_code,
   input  logic [1:0] par_mode,
   input  logic      addr_filter,
   output logic      push,
   output rx_entry_t push_entry,
   output logic      push_addr,
   output logic      busy
);
   if (PH_W < 4) begin : g_bad_phase
      $error("uart_rx_frame: PH_W must hold 16 phases");
   end

   rx_state_e              state_q;
   logic [PH_W-1:0]        phase_q;
   logic [RX_IDX_W-1:0]    idx_q;
   logic [RX_MAX_BITS-1:0] sh_q;
   logic                   s0_q, s1_q, pe_q;

   logic [PH_W-1:0]     ph_last, ph_mid;
   logic [RX_IDX_W-1:0] last_idx;
   logic                vote, at_vote, at_wrap, stop_done;

   assign ph_last   = dbl ? PH_W'(7) : PH_W'(15);
   assign ph_mid    = dbl ? PH_W'(4) : PH_W'(8);
   assign last_idx  = last_bit_idx(len_code);
   assign vote      = maj3(s0_q, s1_q, rxd);
   assign at_vote   = tick && (state_q != ST_HUNT) && (phase_q == ph_mid + 1'b1);
   assign at_wrap   = tick && (state_q != ST_HUNT) && (phase_q == ph_last);
   assign stop_done = rx_en && at_vote && (state_q == ST_STOP);

   assign push_addr        = sh_q[last_idx];
   assign push             = stop_done && (!addr_filter || push_addr);
   assign push_entry.data  = sh_q;
   assign push_entry.fe    = !vote;
   assign push_entry.pe    = pe_q;
   assign busy             = (state_q != ST_HUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         phase_q <= '0;
         idx_q   <= '0;
         sh_q    <= '0;
         s0_q    <= 1'b1;
         s1_q    <= 1'b1;
         pe_q    <= 1'b0;
      end else if (!rx_en) begin
         state_q <= ST_HUNT;
      end else if (tick) begin
         if (state_q == ST_HUNT) begin
            if (!rxd) begin
               state_q <= ST_START;
               phase_q <= PH_W'(1);
               idx_q   <= '0;
               sh_q    <= '0;
               pe_q    <= 1'b0;
            end
         end else begin
            phase_q <= (phase_q == ph_last) ? '0 : phase_q + 1'b1;
            if (phase_q == ph_mid - 1'b1) s0_q <= rxd;
            if (phase_q == ph_mid)        s1_q <= rxd;
            if (at_vote) begin
               unique case (state_q)
                  ST_START:  if (vote) state_q <= ST_HUNT;
                  ST_DATA:   sh_q[idx_q] <= vote;
                  ST_PARITY: pe_q <= (^sh_q) ^ vote ^ par_mode[0];
                  default:   state_q <= ST_HUNT;
               endcase
            end else if (at_wrap) begin
               unique case (state_q)
                  ST_START:  state_q <= ST_DATA;
                  ST_DATA:   if (idx_q == last_idx) state_q <= par_mode[1] ? ST_PARITY : ST_STOP;
                             else idx_q <= idx_q + 1'b1;
                  ST_PARITY: state_q <= ST_STOP;
                  default:   state_q <= state_q;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int DEPTH = 2,
   parameter int W     = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         rovr,
   output logic         valid,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_rx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem_q [DEPTH];
   logic          ovr_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q, newest;
   logic [AW:0]   cnt_q;
   logic          push_ok, pop_ok, ovr_mark;

   assign valid    = (cnt_q != '0);
   assign full     = (cnt_q == (AW+1)'(DEPTH));
   assign pop_ok   = pop && valid;
   assign push_ok  = push && (!full || pop_ok);
   assign ovr_mark = push && full && !pop_ok;
   assign newest   = wp_q - 1'b1;
   assign rdata    = mem_q[rp_q];
   assign rovr     = ovr_q[rp_q];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_q[i] <= '0;
            ovr_q[i] <= 1'b0;
         end else if (push_ok && wp_q == AW'(i)) begin
            mem_q[i] <= wdata;
            ovr_q[i] <= 1'b0;
         end else if (ovr_mark && newest == AW'(i)) begin
            ovr_q[i] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + 1'b1;
         if (pop_ok)  rp_q <= rp_q + 1'b1;
         unique case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_maj.sv
module uart_rx_maj
   import uart_rx_pkg::*;
#(
   parameter int DIV_W      = 12,
   parameter int FIFO_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rxd,
   input  logic             rx_en,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             dbl_speed,
   input  logic [2:0]       len_code,
   input  logic [1:0]       par_mode,
   input  logic             addr_filter,
   input  logic             rd_strobe,
   output logic             rx_valid,
   output logic [7:0]       rx_data,
   output logic             rx_bit8,
   output logic             err_frame,
   output logic             err_parity,
   output logic             err_overrun
);
   localparam int EW = $bits(rx_entry_t);

   logic      tick, push, push_addr, busy, fifo_full;
   rx_entry_t push_entry, head;
   logic [EW-1:0] head_raw;

   uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
   );

   uart_rx_frame u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en),
      .dbl(dbl_speed), .len_code(len_code), .par_mode(par_mode),
      .addr_filter(addr_filter), .push(push), .push_entry(push_entry),
      .push_addr(push_addr), .busy(busy)
   );

   uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_entry),
      .pop(rd_strobe), .rdata(head_raw), .rovr(err_overrun),
      .valid(rx_valid), .full(fifo_full)
   );

   assign head       = rx_entry_t'(head_raw);
   assign rx_data    = head.data[7:0];
   assign rx_bit8    = head.data[RX_MAX_BITS-1];
   assign err_frame  = head.fe;
   assign err_parity = head.pe;
endmodule

// File: rtl/uart_rx_maj_chk.sv
module uart_rx_maj_chk #(
   parameter int DIV_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_en,
   input logic             addr_filter,
   input logic             rd_strobe,
   input logic             rx_valid,
   input logic [DIV_W-1:0] baud_div,
   input logic             tick,
   input logic             push,
   input logic             push_addr,
   input logic             busy
);
   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && baud_div != '0) |=> !tick);                       // R1
   AST_OFF_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> !push);                                         // R9
   AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !busy);                                         // R9
   AST_FILTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (push && addr_filter) |-> push_addr);                      // R10
   AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rd_strobe) |=> rx_valid);                    // R7
endmodule

bind uart_rx_maj uart_rx_maj_chk #(.DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .addr_filter(addr_filter),
   .rd_strobe(rd_strobe), .rx_valid(rx_valid), .baud_div(baud_div),
   .tick(tick), .push(push), .push_addr(push_addr), .busy(busy)
);

// File: tb/uart_rx_maj_tb.sv
`timescale 1ns/1ps
module uart_rx_maj_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       rx_en = 1'b1;
   logic [11:0] baud_div = 12'd3;
   logic       dbl_speed = 1'b0;
   logic [2:0] len_code = 3'd3;
   logic [1:0] par_mode = 2'b00;
   logic       addr_filter = 1'b0;
   logic       rd_strobe = 1'b0;
   logic       rx_valid, rx_bit8, err_frame, err_parity, err_overrun;
   logic [7:0] rx_data;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   uart_rx_maj u_dut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .baud_div(baud_div),
      .dbl_speed(dbl_speed), .len_code(len_code), .par_mode(par_mode),
      .addr_filter(addr_filter), .rd_strobe(rd_strobe), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_bit8(rx_bit8), .err_frame(err_frame),
      .err_parity(err_parity), .err_overrun(err_overrun)
   );

   typedef struct packed {
      logic [2:0] code;
      logic [1:0] pm;
      logic [8:0] d;
      logic       badp;
      logic       stopl;
      logic       dbl;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{3'd3, 2'b00, 9'h0A5, 1'b0, 1'b1, 1'b0},
      '{3'd0, 2'b10, 9'h1F3, 1'b0, 1'b1, 1'b0},
      '{3'd1, 2'b11, 9'h02D, 1'b1, 1'b1, 1'b0},
      '{3'd2, 2'b10, 9'h055, 1'b0, 1'b0, 1'b0},
      '{3'd4, 2'b00, 9'h1C3, 1'b0, 1'b1, 1'b0},
      '{3'd4, 2'b11, 9'h0FF, 1'b0, 1'b1, 1'b0},
      '{3'd3, 2'b10, 9'h03C, 1'b0, 1'b1, 1'b1},
      '{3'd2, 2'b11, 9'h07F, 1'b1, 1'b0, 1'b1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int nbits(input logic [2:0] code);
      return (code >= 3'd4) ? 9 : int'(code) + 5;
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int bit_clks();
      return (dbl_speed ? 8 : 16) * (int'(baud_div) + 1);
   endfunction

   task automatic send(input logic [2:0] code, input logic [1:0] pm, input logic [8:0] d,
                       input logic badp, input logic stopl, input logic dblm);
      int n;
      int bt;
      logic p;
      @(negedge clk);
      dbl_speed = dblm;
      len_code  = code;
      par_mode  = pm;
      n  = nbits(code);
      bt = bit_clks();
      wait_clk(bt);
      rxd = 1'b0;
      wait_clk(bt);
      p = 1'b0;
      for (int i = 0; i < n; i++) begin
         rxd = d[i];
         p = p ^ d[i];
         wait_clk(bt);
      end
      if (pm[1]) begin
         rxd = p ^ pm[0] ^ badp;
         wait_clk(bt);
      end
      rxd = stopl;
      wait_clk(bt);
      rxd = 1'b1;
      wait_clk(bt);
   endtask

   task automatic pop();
      @(negedge clk);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      wait_clk(5);
      // reset state: FIFO empty, head flags clear (R7)
      chk("R7 reset rx_valid", rx_valid, 0);
      chk("R7 reset flags", {err_frame, err_parity, err_overrun}, 0);
      rst_n = 1'b1;
      wait_clk(3);

      // vector table: lengths (R4), parity (R5), stop check (R6), speeds (R2)
      for (int v = 0; v < 8; v++) begin
         int n;
         logic [8:0] exp_d;
         n = nbits(VECS[v].code);
         exp_d = VECS[v].d & 9'((1 << n) - 1);
         send(VECS[v].code, VECS[v].pm, VECS[v].d, VECS[v].badp, VECS[v].stopl, VECS[v].dbl);
         chk($sformatf("R2 vec%0d valid", v), rx_valid, 1);
         chk($sformatf("R4 vec%0d data", v), rx_data, exp_d[7:0]);
         chk($sformatf("R4 vec%0d bit8", v), rx_bit8, exp_d[8]);
         chk($sformatf("R5 vec%0d parity err", v), err_parity, VECS[v].pm[1] & VECS[v].badp);
         chk($sformatf("R6 vec%0d frame err", v), err_frame, !VECS[v].stopl);
         chk($sformatf("R8 vec%0d overrun", v), err_overrun, 0);
         pop();
         chk($sformatf("R7 vec%0d empty after read", v), rx_valid, 0);
      end

      // R1: divisor 0, tick every clock, 9-bit frame
      baud_div = 12'd0;
      send(3'd4, 2'b10, 9'h12B, 1'b0, 1'b1, 1'b0);
      chk("R1 div0 valid", rx_valid, 1);
      chk("R1 div0 data", {rx_bit8, rx_data}, 9'h12B);
      chk("R1 div0 parity", err_parity, 0);
      pop();
      baud_div = 12'd3;

      // R3: short low spike is voted away, then a real frame arrives
      @(negedge clk);
      rxd = 1'b0;
      wait_clk(8);
      rxd = 1'b1;
      wait_clk(4 * 64);
      chk("R3 spike ignored", rx_valid, 0);
      send(3'd3, 2'b00, 9'h05A, 1'b0, 1'b1, 1'b0);
      chk("R3 frame after spike", rx_data, 8'h5A);
      pop();

      // R8: three frames, no reads; third lost, second flagged
      send(3'd3, 2'b00, 9'h011, 1'b0, 1'b1, 1'b0);
      send(3'd3, 2'b00, 9'h022, 1'b0, 1'b1, 1'b0);
      send(3'd3, 2'b00, 9'h033, 1'b0, 1'b1, 1'b0);
      chk("R8 head data", rx_data, 8'h11);
      chk("R8 head no overrun", err_overrun, 0);
      pop();
      chk("R8 second data", rx_data, 8'h22);
      chk("R8 second overrun", err_overrun, 1);
      pop();
      chk("R8 third lost", rx_valid, 0);

      // R9: disable mid-frame; stored entry kept, partial frame gone
      send(3'd3, 2'b00, 9'h0C4, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      rxd = 1'b0;
      wait_clk(64);
      rxd = 1'b1;
      wait_clk(32);
      rx_en = 1'b0;
      wait_clk(32);
      for (int i = 0; i < 10; i++) begin
         rxd = i[0];
         wait_clk(64);
      end
      rxd = 1'b1;
      wait_clk(64);
      rx_en = 1'b1;
      wait_clk(64);
      chk("R9 entry kept", rx_data, 8'hC4);
      pop();
      chk("R9 partial discarded", rx_valid, 0);

      // R10: address filter
      addr_filter = 1'b1;
      send(3'd3, 2'b00, 9'h012, 1'b0, 1'b1, 1'b0);
      chk("R10 non-address dropped", rx_valid, 0);
      send(3'd3, 2'b00, 9'h093, 1'b0, 1'b1, 1'b0);
      chk("R10 address kept", rx_data, 8'h93);
      pop();
      chk("R10 single entry", rx_valid, 0);
      addr_filter = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule